// File: doc/BRIEF.md
# Redistributor Control and Type Registers

This block is the per-core register window of an interrupt redistributor. A core-side agent reaches it through a plain memory-mapped port. Each access carries a byte offset, a width flag (32 or 64 bits), a write flag and write data. The block holds one writable control bit that switches message-based (LPI) interrupt delivery on and off. It also presents a read-only 64-bit type word, assembled from static configuration inputs: the owning core's affinity, its core number, whether this redistributor is the highest-allocated one in its region, and whether LPIs are supported at all.

When a control write changes the LPI-enable bit, the block emits a single-cycle pulse to the machinery further down. Turning the bit off produces a flush pulse, which discards pending LPIs. Turning it on produces a start pulse, which begins LPI delivery. Read data comes back one clock after the read access, together with a valid strobe.

Register layout (byte offsets): control at 0x00, type word at 0x08 (low half) and 0x0C (high half), status at 0x10, wake at 0x14.

Top module: `rdist_ctrl_regs`

## Requirements
- R1: After reset the LPI-enable bit is 0, reading control at 0x00 returns 0, and `rd_valid`, `lpi_flush_pulse` and `lpi_start_pulse` are 0.
- R2: Bits [55:32] of the type word equal `cfg_affinity`.
- R3: Bits [23:8] of the type word equal `cfg_core_num`.
- R4: Bit 4 of the type word equals `cfg_last`.
- R5: Bit 0 of the type word equals `cfg_lpi_cap`. All other type bits read 0.
- R6: Three read forms of the type word are supported:
  - a 64-bit read at 0x08 returns the whole word;
  - a 32-bit read at 0x08 returns bits [31:0];
  - a 32-bit read at 0x0C returns bits [63:32] in `rd_data[31:0]`.
  
  In the two 32-bit forms, `rd_data[63:32]` is 0.
- R7: A control write while `cfg_lpi_cap` is 0 changes nothing and raises no pulse.
- R8: A control write with data bit 0 = 1 while the enable bit is 0 sets the bit. `lpi_start_pulse` is then high for exactly the one cycle after the write.
- R9: A control write with data bit 0 = 0 while the enable bit is 1 clears the bit. `lpi_flush_pulse` is then high for exactly the one cycle after the write.
- R10: A control write that leaves the enable bit unchanged raises neither pulse.
- R11: Status (0x10) and wake (0x14) read as zero. Writes to them, and to the type word, have no effect.
- R12: An access to an unmapped offset, or a 64-bit access not aligned to 8 bytes, reads zero and changes no state.
- R13: `rd_valid` is high exactly in the cycle after a read access. `rd_data` is zero whenever `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| acc_offset | input | OFS_W | Byte offset within the frame |
| acc_wdata | input | 64 | Write data |
| cfg_affinity | input | AFF_W | Affinity of the owning core |
| cfg_core_num | input | CORE_W | Core number |
| cfg_last | input | 1 | Highest-allocated redistributor in its region |
| cfg_lpi_cap | input | 1 | LPI support present |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| lpi_flush_pulse | output | 1 | One-cycle flush request on disable |
| lpi_start_pulse | output | 1 | One-cycle start request on enable |

## Verification
The bench targets the following corner cases:
- **Repeated control writes.** A design that derives its pulses from the write itself, rather than from a change of the bit, would pulse on every write.
- **Capability dropped while enabled.** Once `cfg_lpi_cap` goes low, a disable write must be refused. A design that gates only the set direction would clear the bit and fire a spurious flush.
- **Upper-half and misaligned reads of the type word.** A wrong shift would put the affinity in the wrong lane, or leak type bits through a misaligned 64-bit access.
- **Writes to the type, status and unmapped offsets.** A loose decode would let such a write set the enable bit.

// File: rtl/rdist_pkg.sv
package rdist_pkg;

   // Fixed bit positions of the type word, decoded by software and neighbours
   localparam int unsigned TYPE_W        = 64;
   localparam int unsigned TYPE_AFF_LSB  = 32;
   localparam int unsigned TYPE_CORE_LSB = 8;
   localparam int unsigned TYPE_LAST_BIT = 4;
   localparam int unsigned TYPE_PLPI_BIT = 0;
   localparam int unsigned CTRL_EN_BIT   = 0;

   // 64-bit word indices inside the frame
   localparam int unsigned WORD_CTRL = 0;
   localparam int unsigned WORD_TYPE = 1;
   localparam int unsigned WORD_IDLE = 2;   // status (low half), wake (high half)

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_TYPE = 2'd2,
      SEL_ZERO = 2'd3
   } rsel_e;

   typedef struct packed {
      rsel_e sel;
      logic  upper;
      logic  wide;
   } dec_t;

endpackage

// File: rtl/rdist_decode.sv
module rdist_decode
   import rdist_pkg::*;
#(
   parameter int unsigned OFS_W = 16
) (
   input  logic [OFS_W-1:0] ofs,
   input  logic             wide,
   output dec_t             dec
);

   localparam int unsigned WIDX_W = OFS_W - 3;

   logic [WIDX_W-1:0] widx;
   logic              aligned;

   assign widx    = ofs[OFS_W-1:3];
   assign aligned = wide ? (ofs[2:0] == 3'b000) : (ofs[1:0] == 2'b00);

   always_comb begin
      dec.upper = ofs[2];
      dec.wide  = wide;
      dec.sel   = SEL_NONE;
      if (aligned) begin
         if (widx == WIDX_W'(WORD_CTRL))
            dec.sel = SEL_CTRL;
         else if (widx == WIDX_W'(WORD_TYPE))
            dec.sel = SEL_TYPE;
         else if (widx == WIDX_W'(WORD_IDLE))
            dec.sel = SEL_ZERO;
      end
   end

endmodule

// File: rtl/rdist_typer.sv
module rdist_typer
   import rdist_pkg::*;
#(
   parameter int unsigned AFF_W  = 24,
   parameter int unsigned CORE_W = 16
) (
   input  logic [AFF_W-1:0]  aff,
   input  logic [CORE_W-1:0] core,
   input  logic              last,
   input  logic              cap,
   output logic [TYPE_W-1:0] word
);

   always_comb begin
      word                           = '0;
      word[TYPE_AFF_LSB +: AFF_W]    = aff;
      word[TYPE_CORE_LSB +: CORE_W]  = core;
      word[TYPE_LAST_BIT]            = last;
      word[TYPE_PLPI_BIT]            = cap;
   end

endmodule

// File: rtl/rdist_ctrl.sv
module rdist_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_bit,
   input  logic cap,
   output logic en,
   output logic flush_p,
   output logic start_p
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en      <= 1'b0;
         flush_p <= 1'b0;
         start_p <= 1'b0;
      end else begin
         flush_p <= 1'b0;
         start_p <= 1'b0;
         if (wr_en && cap) begin
            en      <= wr_bit;
            flush_p <= en & ~wr_bit;
            start_p <= ~en & wr_bit;
         end
      end
   end

endmodule

// File: rtl/rdist_ctrl_regs.sv
module rdist_ctrl_regs
   import rdist_pkg::*;
#(
   parameter int unsigned OFS_W      = 16,
   parameter int unsigned AFF_W      = 24,
   parameter int unsigned CORE_W     = 16,
   parameter int unsigned RD_LATENCY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_wide,
   input  logic [OFS_W-1:0]  acc_offset,
   input  logic [63:0]       acc_wdata,
   input  logic [AFF_W-1:0]  cfg_affinity,
   input  logic [CORE_W-1:0] cfg_core_num,
   input  logic              cfg_last,
   input  logic              cfg_lpi_cap,
   output logic              rd_valid,
   output logic [63:0]       rd_data,
   output logic              lpi_flush_pulse,
   output logic              lpi_start_pulse
);

   localparam int unsigned HALF_W = TYPE_W / 2;

   // Elaboration-time parameter checks
   if (AFF_W > 24 || AFF_W == 0) begin : g_bad_aff
      $error("AFF_W must be 1..24");
   end
   if (CORE_W > 16 || CORE_W == 0) begin : g_bad_core
      $error("CORE_W must be 1..16");
   end
   if (OFS_W < 5) begin : g_bad_ofs
      $error("OFS_W must cover the register window");
   end
   if (RD_LATENCY > 1) begin : g_bad_lat
      $error("RD_LATENCY must be 0 or 1");
   end

   dec_t              dec;
   logic [TYPE_W-1:0] type_word;
   logic              lpi_en;
   logic              ctrl_wr;
   logic              rd_acc;
   logic [TYPE_W-1:0] sel_word;
   logic [TYPE_W-1:0] rd_next;

   rdist_decode #(.OFS_W(OFS_W)) u_dec (
      .ofs  (acc_offset),
      .wide (acc_wide),
      .dec  (dec)
   );

   rdist_typer #(.AFF_W(AFF_W), .CORE_W(CORE_W)) u_typer (
      .aff  (cfg_affinity),
      .core (cfg_core_num),
      .last (cfg_last),
      .cap  (cfg_lpi_cap),
      .word (type_word)
   );

   assign ctrl_wr = acc_valid && acc_write && (dec.sel == SEL_CTRL) && !dec.upper;
   assign rd_acc  = acc_valid && !acc_write;

   rdist_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctrl_wr),
      .wr_bit  (acc_wdata[CTRL_EN_BIT]),
      .cap     (cfg_lpi_cap),
      .en      (lpi_en),
      .flush_p (lpi_flush_pulse),
      .start_p (lpi_start_pulse)
   );

   // Read path: select the 64-bit view, shift to the addressed half, trim
   always_comb begin
      sel_word = '0;
      case (dec.sel)
         SEL_CTRL: sel_word[CTRL_EN_BIT] = lpi_en;
         SEL_TYPE: sel_word = type_word;
         default:  sel_word = '0;
      endcase
      rd_next = dec.upper ? (sel_word >> HALF_W) : sel_word;
      if (!dec.wide)
         rd_next[TYPE_W-1:HALF_W] = '0;
      if (!rd_acc)
         rd_next = '0;
   end

   if (RD_LATENCY == 1) begin : g_rd_reg
      logic              rd_valid_q;
      logic [TYPE_W-1:0] rd_data_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
         end else begin
            rd_valid_q <= rd_acc;
            rd_data_q  <= rd_next;
         end
      end
      assign rd_valid = rd_valid_q;
      assign rd_data  = rd_data_q;
   end else begin : g_rd_comb
      assign rd_valid = rd_acc;
      assign rd_data  = rd_next;
   end

endmodule

// File: rtl/rdist_regs_chk.sv
module rdist_regs_chk #(
   parameter int unsigned RD_LATENCY = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_valid,
   input logic        acc_write,
   input logic        cfg_lpi_cap,
   input logic        rd_valid,
   input logic [63:0] rd_data,
   input logic        lpi_flush_pulse,
   input logic        lpi_start_pulse,
   input logic        lpi_en
);

   // R1: enable bit is clear on the first cycle out of reset
   assert_reset_clear_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!lpi_en && !lpi_flush_pulse && !lpi_start_pulse));

   // R7: the enable bit only moves after a cycle with capability present
   assert_cap_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lpi_en) |-> $past(cfg_lpi_cap));

   // R8: start pulse accompanies a 0->1 transition of the bit
   assert_start_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lpi_start_pulse |-> (lpi_en && !$past(lpi_en)));

   // R9: flush pulse accompanies a 1->0 transition of the bit
   assert_flush_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lpi_flush_pulse |-> (!lpi_en && $past(lpi_en)));

   // R10: no pulse while the bit holds its value
   assert_no_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(lpi_en) |-> (!lpi_flush_pulse && !lpi_start_pulse));

   // R13: read data is zero outside valid cycles
   assert_rd_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == 64'd0));

   if (RD_LATENCY == 1) begin : g_lat1
      // R13: valid only in the cycle after a read access
      assert_rd_valid_R13: assert property (@(posedge clk) disable iff (!rst_n)
         rd_valid |-> $past(acc_valid && !acc_write));
   end

endmodule

bind rdist_ctrl_regs rdist_regs_chk #(.RD_LATENCY(RD_LATENCY)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .acc_valid       (acc_valid),
   .acc_write       (acc_write),
   .cfg_lpi_cap     (cfg_lpi_cap),
   .rd_valid        (rd_valid),
   .rd_data         (rd_data),
   .lpi_flush_pulse (lpi_flush_pulse),
   .lpi_start_pulse (lpi_start_pulse),
   .lpi_en          (lpi_en)
);

// File: tb/test_rdist_ctrl_regs.sv
`timescale 1ns/1ps
module test_rdist_ctrl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic        acc_wide = 1'b0;
   logic [15:0] acc_offset = '0;
   logic [63:0] acc_wdata = '0;
   logic [23:0] cfg_affinity = 24'hA5C3E1;
   logic [15:0] cfg_core_num = 16'h1234;
   logic        cfg_last = 1'b1;
   logic        cfg_lpi_cap = 1'b1;
   logic        rd_valid;
   logic [63:0] rd_data;
   logic        lpi_flush_pulse;
   logic        lpi_start_pulse;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      logic        rd;
      logic [63:0] data;
      logic        fl;
      logic        st;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;

   rdist_ctrl_regs i_rdist_ctrl_regs (
      .clk             (clk),
      .rst_n           (rst_n),
      .acc_valid       (acc_valid),
      .acc_write       (acc_write),
      .acc_wide        (acc_wide),
      .acc_offset      (acc_offset),
      .acc_wdata       (acc_wdata),
      .cfg_affinity    (cfg_affinity),
      .cfg_core_num    (cfg_core_num),
      .cfg_last        (cfg_last),
      .cfg_lpi_cap     (cfg_lpi_cap),
      .rd_valid        (rd_valid),
      .rd_data         (rd_data),
      .lpi_flush_pulse (lpi_flush_pulse),
      .lpi_start_pulse (lpi_start_pulse)
   );

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Driver: one access per call, expectation pushed to the scoreboard
   task automatic acc(input logic wr, input logic wide, input logic [15:0] ofs,
                      input logic [63:0] wd, input logic [63:0] exp_d,
                      input logic exp_fl, input logic exp_st, input string tag);
      exp_t e;
      @(negedge clk);
      acc_valid  = 1'b1;
      acc_write  = wr;
      acc_wide   = wide;
      acc_offset = ofs;
      acc_wdata  = wd;
      e.rd = ~wr; e.data = exp_d; e.fl = exp_fl; e.st = exp_st; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      acc_valid = 1'b0;
      acc_write = 1'b0;
   endtask

   // Monitor: compares outputs one cycle after each sampled access
   initial begin
      forever begin
         logic v;
         exp_t e;
         @(posedge clk);
         v = acc_valid && rst_n;
         @(negedge clk);
         if (v) begin
            n_chk++;
            if (sb.size() == 0) begin
               n_fail++;
               $display("FAIL scoreboard: output with no expectation, rd_data=%h expected none", rd_data);
            end else begin
               e = sb.pop_front();
               if (rd_valid !== e.rd || rd_data !== e.data ||
                   lpi_flush_pulse !== e.fl || lpi_start_pulse !== e.st) begin
                  n_fail++;
                  $display("FAIL %s: valid=%b data=%h flush=%b start=%b expected valid=%b data=%h flush=%b start=%b",
                           e.tag, rd_valid, rd_data, lpi_flush_pulse, lpi_start_pulse,
                           e.rd, e.data, e.fl, e.st);
               end
            end
         end
      end
   end

   initial begin
      #100000;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet outputs after reset
      n_chk++;
      if (rd_valid !== 1'b0 || rd_data !== 64'd0 || lpi_flush_pulse !== 1'b0 || lpi_start_pulse !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: valid=%b data=%h flush=%b start=%b expected 0 0 0 0",
                  rd_valid, rd_data, lpi_flush_pulse, lpi_start_pulse);
      end

      // R2 R3 R4 R5 R6: type word forms
      acc(0, 1, 16'h0008, 0, 64'h00A5C3E1_00123411, 0, 0, "R2_R3_R4_R5 full type");
      acc(0, 0, 16'h0008, 0, 64'h00000000_00123411, 0, 0, "R6 low half");
      acc(0, 0, 16'h000C, 0, 64'h00000000_00A5C3E1, 0, 0, "R6 high half");
      acc(0, 0, 16'h0000, 0, 64'd0, 0, 0, "R1 control after reset");

      // R8 R10 R9
      acc(1, 0, 16'h0000, 64'd1, 64'd0, 0, 1, "R8 enable start pulse");
      acc(0, 0, 16'h0000, 0, 64'd1, 0, 0, "R8 enable readback, pulse one cycle");
      acc(1, 0, 16'h0000, 64'd1, 64'd0, 0, 0, "R10 rewrite one no pulse");
      acc(1, 0, 16'h0000, 64'd0, 64'd0, 1, 0, "R9 disable flush pulse");
      acc(0, 0, 16'h0000, 0, 64'd0, 0, 0, "R9 disable readback");
      acc(1, 0, 16'h0000, 64'd0, 64'd0, 0, 0, "R10 rewrite zero no pulse");

      // R11: read-only and zero registers
      acc(1, 1, 16'h0008, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 0, "R11 type write");
      acc(0, 1, 16'h0008, 0, 64'h00A5C3E1_00123411, 0, 0, "R11 type unchanged");
      acc(1, 0, 16'h0010, 64'hFFFF_FFFF, 64'd0, 0, 0, "R11 status write");
      acc(0, 0, 16'h0010, 0, 64'd0, 0, 0, "R11 status reads zero");
      acc(1, 0, 16'h0014, 64'hFFFF_FFFF, 64'd0, 0, 0, "R11 wake write");
      acc(0, 0, 16'h0014, 0, 64'd0, 0, 0, "R11 wake reads zero");

      // R12: unmapped and misaligned
      acc(1, 0, 16'h0040, 64'd1, 64'd0, 0, 0, "R12 unmapped write");
      acc(1, 1, 16'h0004, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 0, "R12 misaligned wide write");
      acc(0, 0, 16'h0000, 0, 64'd0, 0, 0, "R12 control untouched");
      acc(0, 0, 16'h0040, 0, 64'd0, 0, 0, "R12 unmapped read");
      acc(0, 1, 16'h000C, 0, 64'd0, 0, 0, "R12 misaligned wide read");

      // R4 R5 R7: capability and last flag removed
      idle();
      cfg_last    = 1'b0;
      cfg_lpi_cap = 1'b0;
      acc(0, 1, 16'h0008, 0, 64'h00A5C3E1_00123400, 0, 0, "R4_R5 flags clear");
      acc(1, 0, 16'h0000, 64'd1, 64'd0, 0, 0, "R7 enable refused");
      acc(0, 0, 16'h0000, 0, 64'd0, 0, 0, "R7 control still zero");

      // R7: disable refused once capability drops while enabled
      idle();
      cfg_lpi_cap = 1'b1;
      acc(1, 0, 16'h0000, 64'd1, 64'd0, 0, 1, "R8 enable again");
      idle();
      cfg_lpi_cap = 1'b0;
      acc(1, 0, 16'h0000, 64'd0, 64'd0, 0, 0, "R7 disable refused");
      acc(0, 0, 16'h0000, 0, 64'd1, 0, 0, "R7 bit kept");

      // R13: valid drops after the access stream
      idle();
      @(negedge clk);
      n_chk++;
      if (rd_valid !== 1'b0 || rd_data !== 64'd0) begin
         n_fail++;
         $display("FAIL R13: valid=%b data=%h expected 0 0", rd_valid, rd_data);
      end
      repeat (2) @(negedge clk);
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: %0d expectations left, expected 0", sb.size());
      end
      finish_run();
   end

endmodule